// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block catches software that has lost its way. A 7-bit down-counter steps once per prescaler period of the system clock. While the watchdog is armed, software must reload the counter inside a permitted window. The reload must come late enough, meaning the count has fallen to or below a programmed window value. It must also come early enough, before the count's top bit clears. A reload outside that window, or no reload at all, raises a reset request that stays high until the block's own reset.

The watchdog is armed either by a hardware option input or by a software control write with the arm bit set. Arming is one-way: no later write can disarm it, and only a reset clears it. The control write carries the arm bit above the count bits. The window register holds a compare value of the same width as the count. Setting the window to all ones makes every reload legal, so the block then acts as a plain timeout watchdog.

Top module: `win_watchdog`

## Requirements
- R1: After reset the count reads all ones (0x7F), the window reads all ones (0x7F), the armed flag is 0 while the hardware arm input is low, and the reset request is 0.
- R2: Without control writes, the count decreases by exactly one every PRESC clock cycles and wraps from 0x00 to 0x7F.
- R3: A control write loads the count from write bits [6:0] in the same clock edge and restarts the prescaler, so the next decrement comes PRESC cycles after the write. Write bit 7 set arms the watchdog.
- R4: The hardware arm input held high arms the watchdog at the next clock edge.
- R5: Once armed, the watchdog stays armed; a control write with bit 7 clear does not disarm it.
- R6: When armed and the count steps from 0x40 to 0x3F, the reset request rises on the following clock edge.
- R7: When armed, a control write made while the count is strictly greater than the window value raises the reset request on that write's clock edge.
- R8: When armed, a control write made while the count is at or below the window value and loads a value with bit 6 set raises no reset request.
- R9: A control write that loads a value with bit 6 clear raises the reset request one edge later when the watchdog is armed, or is being armed by that same write.
- R10: With the window at 0x7F, a reload at any count value from 0x7F down to 0x40 raises no reset request.
- R11: The reset request, once high, stays high through any writes and counting until reset.
- R12: While not armed, no count value and no write raises the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_arm | input | 1 | Hardware option arm; high arms the watchdog |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | CW+1 | Control write data: bit CW arms, bits CW-1:0 are the reload count |
| win_we | input | 1 | Window write strobe |
| win_wdata | input | CW | New window compare value |
| cnt_q | output | CW | Current count |
| win_q | output | CW | Current window value |
| armed | output | 1 | Watchdog armed |
| rst_req | output | 1 | Sticky reset request |

## Verification
The bench builds the block with PRESC=4 and CW=7. This shrinks a full pass of the count range to a few hundred cycles but keeps the real count width. As a result, every start value from 0x40 to 0x7F is run to its timeout and checked for the exact edge of the request. Every reload position across the whole legal count range is also tried against four window values, including the all-ones window. Free-running wrap, load timing against the prescaler, the one-way arming and the stickiness of the request are checked on the same configuration.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int PRESC = 12288,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_arm,
  input  logic          ctl_we,
  input  logic [CW:0]   ctl_wdata,
  input  logic          win_we,
  input  logic [CW-1:0] win_wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] win_q,
  output logic          armed,
  output logic          rst_req
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);
  localparam int MSB = CW - 1;

  logic [PW-1:0] pre_q;
  logic tick, early, late;

  assign tick  = (pre_q == PLAST);
  assign early = armed && ctl_we && (cnt_q > win_q);
  assign late  = armed && !cnt_q[MSB];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               pre_q <= '0;
    else if (ctl_we || tick)  pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt_q <= '1;
    else if (ctl_we) cnt_q <= ctl_wdata[CW-1:0];
    else if (tick)   cnt_q <= cnt_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      win_q <= '1;
    else if (win_we) win_q <= win_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 armed <= 1'b0;
    else if (hw_arm || (ctl_we && ctl_wdata[CW])) armed <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             rst_req <= 1'b0;
    else if (early || late) rst_req <= 1'b1;
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hw_arm,
  input logic          ctl_we,
  input logic [CW:0]   ctl_wdata,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] win_q,
  input logic          armed,
  input logic          rst_req
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> cnt_q == $past(ctl_wdata[CW-1:0]));
  p_arm_sw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[CW]) |=> armed);
  p_arm_hw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_arm |=> armed);
  p_no_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cnt_q[CW-1]) |=> rst_req);
  p_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ctl_we && cnt_q > win_q) |=> rst_req);
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !rst_req);
endmodule

bind win_watchdog win_watchdog_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_arm(hw_arm), .ctl_we(ctl_we),
  .ctl_wdata(ctl_wdata), .cnt_q(cnt_q), .win_q(win_q),
  .armed(armed), .rst_req(rst_req)
);

// File: tb/sim_win_watchdog.sv
module sim_win_watchdog;
  localparam int PR = 4;
  localparam int CW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, hw_arm = 1'b0, ctl_we = 1'b0, win_we = 1'b0;
  logic [CW:0]   ctl_wdata = '0;
  logic [CW-1:0] win_wdata = '0;
  logic [CW-1:0] cnt_q, win_q;
  logic armed, rst_req;

  win_watchdog #(.PRESC(PR), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_arm(hw_arm), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .win_we(win_we), .win_wdata(win_wdata),
    .cnt_q(cnt_q), .win_q(win_q), .armed(armed), .rst_req(rst_req)
  );

  int total = 0, bad = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic hw);
    @(negedge clk);
    ctl_we = 1'b0; win_we = 1'b0; hw_arm = hw; rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic ctl_wr(input logic [CW:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic win_wr(input logic [CW-1:0] v);
    @(negedge clk);
    win_we = 1'b1; win_wdata = v;
    @(negedge clk);
    win_we = 1'b0;
  endtask

  initial begin
    int wins[4] = '{64, 85, 106, 127};

    do_reset(1'b0);
    chk("R1 count", cnt_q, 127);
    chk("R1 window", win_q, 127);
    chk("R1 armed", armed, 0);
    chk("R1 rst_req", rst_req, 0);

    for (int k = 1; k <= 140; k++) begin
      step(PR);
      chk("R2 free count", cnt_q, (127 - k) & 127);
    end
    chk("R12 no request while disarmed", rst_req, 0);
    ctl_wr(8'h10);
    step(3);
    chk("R12 low load disarmed", rst_req, 0);
    chk("R3 load disarmed", cnt_q, 16);

    do_reset(1'b0);
    ctl_wr(8'h75);
    chk("R3 load value", cnt_q, 'h75);
    chk("R3 bit7 clear stays disarmed", armed, 0);
    step(PR - 1);
    chk("R3 prescaler restart hold", cnt_q, 'h75);
    step(1);
    chk("R3 prescaler restart step", cnt_q, 'h74);

    do_reset(1'b1);
    step(1);
    chk("R4 hw arm", armed, 1);
    step(64 * PR - 1);
    chk("R4 count at timeout point", cnt_q, 63);
    chk("R6 no request yet", rst_req, 0);
    step(1);
    chk("R6 hw armed timeout", rst_req, 1);
    hw_arm = 1'b0;

    do_reset(1'b0);
    ctl_wr(8'hFF);
    chk("R3 bit7 arms", armed, 1);
    ctl_wr(8'h7F);
    chk("R5 stays armed", armed, 1);
    step(10);
    chk("R5 stays armed later", armed, 1);
    chk("R8 legal reload", rst_req, 0);

    for (int v = 64; v <= 127; v++) begin
      do_reset(1'b0);
      ctl_wr(8'h80 | 8'(v));
      step((v - 63) * PR);
      chk("R6 before timeout", rst_req, 0);
      chk("R6 count 0x3F", cnt_q, 63);
      step(1);
      chk("R6 timeout request", rst_req, 1);
    end

    foreach (wins[i]) begin
      for (int k = 0; k <= 63; k++) begin
        int c;
        c = 127 - k;
        do_reset(1'b0);
        win_wr(7'(wins[i]));
        ctl_wr(8'hFF);
        step(k * PR);
        ctl_wr(8'h7F);
        if (wins[i] == 127) begin
          chk("R10 open window reload", rst_req, 0);
        end else if (c > wins[i]) begin
          chk("R7 early reload", rst_req, 1);
        end else begin
          chk("R8 in-window reload", rst_req, 0);
          chk("R8 reloaded count", cnt_q, 127);
        end
      end
    end

    do_reset(1'b0);
    ctl_wr(8'hFF);
    ctl_wr(8'h30);
    chk("R9 not yet", rst_req, 0);
    step(1);
    chk("R9 low reload while armed", rst_req, 1);
    do_reset(1'b0);
    ctl_wr(8'hA0);
    step(1);
    chk("R9 low reload while arming", rst_req, 1);

    ctl_wr(8'h7F);
    win_wr(7'h7F);
    step(20);
    chk("R11 sticky request", rst_req, 1);
    do_reset(1'b0);
    chk("R11 cleared by reset", rst_req, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule